// File: doc/BRIEF.md
# Modulo Up-Counter Timer with Overflow Interrupt

A register-mapped 16-bit timer meant to serve both as a free-running time base and as a programmable event source. The counter climbs from a programmable start value to a programmable modulo value. On the count after it reaches the modulo value it returns to the start value and sets an overflow flag. A level interrupt follows the flag, gated by an enable bit. A power-of-two prescaler stretches each count over 2^PS system clocks.

The counter's clock selection is held as a small state machine with four states: `SRC_OFF` (0, stopped; the shadow buffers may load), `SRC_SYS` (1, counting on the system clock), and `SRC_RSV_A`/`SRC_RSV_B` (2 and 3, both parked: no counting and no shadow loading). Any write to the control register moves the machine to the state written in bits 4:3. The transition out of `SRC_OFF` or a parked state into `SRC_SYS` starts the prescaler from zero. The transition back to `SRC_OFF` opens the shadow path.

Software writes the modulo and start values into shadow buffers. They reach the counter logic only while the clock selection is `SRC_OFF`. Any write to the count register reloads the start value. A strap input selects byte-reversed register access.

Top module: `modcnt_timer`

## Requirements
- R1: After reset, the control, count, modulo (0x08) and start-value (0x4C) registers all read zero, and `irq` is low.
- R2: In state `SRC_SYS` (control bits 4:3 = 1), the counter advances once every 2^PS clocks, where PS is control bits 2:0. The divider is held at zero in any other state, so the first count after entering `SRC_SYS` comes a full 2^PS clocks after the write.
- R3: A count taken while the counter equals the active modulo value reloads the active start value and sets the overflow flag (control bit 7). Any other count adds one, wrapping within 16 bits.
- R4: A write of any data to the count register (0x04) loads the active start value into the counter on that edge. This write takes priority over a count in the same cycle, and that count then sets no flag.
- R5: Writes to 0x08 and 0x4C land in shadow buffers. A buffer is copied to its active register on every clock edge at which the state is `SRC_OFF`. Reads of 0x08 and 0x4C return the active values.
- R6: Writing 0 to control bit 7 clears the overflow flag, and writing 1 to it has no effect. If hardware sets the flag in the same cycle as a clearing write, the flag ends up set.
- R7: `irq` is high exactly when the overflow flag and the interrupt enable (control bit 6) are both 1.
- R8: In states `SRC_RSV_A` and `SRC_RSV_B` (bits 4:3 = 2 or 3), the counter holds and the shadow buffers do not load.
- R9: With `big_endian` high, the four bytes of the write data and of the read data are reversed, on every register.
- R10: The control register reads as {flag bit 7, enable bit 6, 0 in bit 5, state bits 4:3, PS bits 2:0} with zeros above. The count reads zero-extended. Unmapped offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_endian | input | 1 | Strap: reverse register byte order |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench runs a behavioural model of the timer beside the design and compares the interrupt on every clock. It also compares register reads at the points where the corner cases bite.

- Modulo N-1 boundary: a design that reloads one count early or late gives the wrong wrap period.
- Prescaler restart: a divider left free-running would give a short first count after the counter is started.
- Writes to the modulo and start values while the counter runs or is parked: a design that skips the shadow path would show the new value at once.
- Flag clear landing on the wrap cycle: a design where the clear wins would lose an interrupt.
- Reversed byte order, and writes to unmapped offsets: these are checked so that a swap on one direction only, or a decode that aliases, is caught.

// File: rtl/mct_pkg.sv
package mct_pkg;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_MODULO = 8'h08;
    localparam logic [7:0] OFS_INIT   = 8'h4C;

    // Control field positions
    localparam int unsigned B_FLAG = 7;
    localparam int unsigned B_IEN  = 6;
    localparam int unsigned PS_W   = 3;

    // Counter clock-selection state machine
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_RSV_A = 2'd2,
        SRC_RSV_B = 2'd3
    } src_e;

    typedef struct packed {
        logic            flag;
        logic            ien;
        src_e            src;
        logic [PS_W-1:0] ps;
    } ctrl_t;

endpackage

// File: rtl/mct_regif.sv
module mct_regif
    import mct_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              be,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_ctrl,
    output logic              wr_count,
    output logic              wr_mod,
    output logic              wr_init,
    output logic [DATA_W-1:0] wdata_le,
    input  ctrl_t             ctrl,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  mod_act,
    input  logic [CNT_W-1:0]  init_act
);
    localparam int unsigned NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rd_le;
    logic [DATA_W-1:0] rd_sw;
    logic              wstb;

    // Byte reversal in both directions
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign wdata_sw[b*8 +: 8] = wdata[(NBYTES-1-b)*8 +: 8];
        assign rd_sw[b*8 +: 8]    = rd_le[(NBYTES-1-b)*8 +: 8];
    end

    assign wdata_le = be ? wdata_sw : wdata;
    assign rdata    = be ? rd_sw : rd_le;

    assign wstb     = sel && wr;
    assign wr_ctrl  = wstb && (addr == ADDR_W'(OFS_CTRL));
    assign wr_count = wstb && (addr == ADDR_W'(OFS_COUNT));
    assign wr_mod   = wstb && (addr == ADDR_W'(OFS_MODULO));
    assign wr_init  = wstb && (addr == ADDR_W'(OFS_INIT));

    always_comb begin
        rd_le = '0;
        case (addr)
            ADDR_W'(OFS_CTRL):   rd_le = DATA_W'({ctrl.flag, ctrl.ien, 1'b0, ctrl.src, ctrl.ps});
            ADDR_W'(OFS_COUNT):  rd_le = DATA_W'(cnt);
            ADDR_W'(OFS_MODULO): rd_le = DATA_W'(mod_act);
            ADDR_W'(OFS_INIT):   rd_le = DATA_W'(init_act);
            default:             rd_le = '0;
        endcase
    end

endmodule

// File: rtl/mct_ctrl.sv
module mct_ctrl
    import mct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata_lo,
    input  logic       flag_set,
    output ctrl_t      ctrl,
    output logic       run,
    output logic       load_en,
    output logic       irq
);
    src_e            src_q, src_nx;
    logic [PS_W-1:0] ps_q;
    logic            ien_q;
    logic            flag_q;

    // Next-state: a control write moves to the state written in bits 4:3
    always_comb begin
        src_nx = src_q;
        if (wr_ctrl) begin
            unique case (wdata_lo[4:3])
                2'd0: src_nx = SRC_OFF;
                2'd1: src_nx = SRC_SYS;
                2'd2: src_nx = SRC_RSV_A;
                2'd3: src_nx = SRC_RSV_B;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_OFF;
        else        src_q <= src_nx;
    end

    // Outputs of the state machine
    always_comb begin
        unique case (src_q)
            SRC_OFF: begin
                run     = 1'b0;
                load_en = 1'b1;
            end
            SRC_SYS: begin
                run     = 1'b1;
                load_en = 1'b0;
            end
            SRC_RSV_A, SRC_RSV_B: begin
                run     = 1'b0;
                load_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q  <= '0;
            ien_q <= 1'b0;
        end else if (wr_ctrl) begin
            ps_q  <= wdata_lo[PS_W-1:0];
            ien_q <= wdata_lo[B_IEN];
        end
    end

    // Hardware set wins over a software clear; writing 1 does nothing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             flag_q <= 1'b0;
        else if (flag_set)                      flag_q <= 1'b1;
        else if (wr_ctrl && !wdata_lo[B_FLAG])  flag_q <= 1'b0;
    end

    always_comb begin
        ctrl.flag = flag_q;
        ctrl.ien  = ien_q;
        ctrl.src  = src_q;
        ctrl.ps   = ps_q;
    end

    assign irq = flag_q && ien_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(wr_ctrl && !wdata_lo[B_FLAG]) |=> flag_q); // R6
    AST_FLAG_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q && !flag_set |=> !flag_q); // R6
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(flag_set) || $past(wr_ctrl)); // R7

endmodule

// File: rtl/mct_prescale.sv
module mct_prescale #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    assign lim  = DIV_W'((1 << ps) - 1);
    // >= keeps the divider bounded when PS is lowered mid-period
    assign tick = run && (div_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (!run || tick) div_q <= '0;
        else                   div_q <= div_q + DIV_W'(1);
    end

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> div_q == '0); // R2
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps != '0) ##1 $stable(ps) |-> !tick); // R2

endmodule

// File: rtl/mct_counter.sv
module mct_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic             wr_count,
    input  logic             wr_mod,
    input  logic             wr_init,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] mod_act,
    output logic [CNT_W-1:0] init_act,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_buf, init_buf;
    logic [CNT_W-1:0] mod_q, init_q;

    // Shadow buffers take every write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_buf  <= '0;
            init_buf <= '0;
        end else begin
            if (wr_mod)  mod_buf  <= wval;
            if (wr_init) init_buf <= wval;
        end
    end

    // Active copies follow the buffers only while the counter is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q  <= '0;
            init_q <= '0;
        end else if (load_en) begin
            mod_q  <= mod_buf;
            init_q <= init_buf;
        end
    end

    assign wrap = tick && (cnt_q == mod_q) && !wr_count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_count) cnt_q <= init_q;
        else if (wrap)     cnt_q <= init_q;
        else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt      = cnt_q;
    assign mod_act  = mod_q;
    assign init_act = init_q;

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt_q == $past(init_q)); // R3
    AST_CNT_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> cnt_q == $past(init_q)); // R4
    AST_SHADOW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(mod_q) && $stable(init_q)); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_count |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/modcnt_timer.sv
module modcnt_timer
    import mct_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              wr_ctrl, wr_count, wr_mod, wr_init;
    logic [DATA_W-1:0] wdata_le;
    ctrl_t             ctrl;
    logic              run, load_en, tick, wrap;
    logic [CNT_W-1:0]  cnt, mod_act, init_act;
    logic              unused_hi;

    assign unused_hi = ^wdata_le[DATA_W-1:CNT_W];

    mct_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
        .be       (big_endian),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .wr_ctrl  (wr_ctrl),
        .wr_count (wr_count),
        .wr_mod   (wr_mod),
        .wr_init  (wr_init),
        .wdata_le (wdata_le),
        .ctrl     (ctrl),
        .cnt      (cnt),
        .mod_act  (mod_act),
        .init_act (init_act)
    );

    mct_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata_lo (wdata_le[7:0]),
        .flag_set (wrap),
        .ctrl     (ctrl),
        .run      (run),
        .load_en  (load_en),
        .irq      (irq)
    );

    mct_prescale #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ps    (ctrl.ps),
        .tick  (tick)
    );

    mct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_en  (load_en),
        .wr_count (wr_count),
        .wr_mod   (wr_mod),
        .wr_init  (wr_init),
        .wval     (wdata_le[CNT_W-1:0]),
        .cnt      (cnt),
        .mod_act  (mod_act),
        .init_act (init_act),
        .wrap     (wrap)
    );

endmodule

// File: tb/sim_modcnt_timer.sv
module sim_modcnt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #10 clk = ~clk;

    modcnt_timer u0 (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Behavioural reference model
    int m_cnt, m_div, m_mbuf, m_mact, m_ibuf, m_iact, m_ps, m_src, m_ien, m_flag;

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v;
        case (a)
            8'h00: v = 32'(m_flag*128 + m_ien*64 + m_src*8 + m_ps);
            8'h04: v = 32'(m_cnt);
            8'h08: v = 32'(m_mact);
            8'h4C: v = 32'(m_iact);
            default: v = 32'h0;
        endcase
        return big_endian ? swap32(v) : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_div = 0; m_mbuf = 0; m_mact = 0; m_ibuf = 0;
            m_iact = 0; m_ps = 0; m_src = 0; m_ien = 0; m_flag = 0;
        end else begin
            logic [31:0] d;
            bit w, run, tick, setf;
            int n_cnt, n_div, n_flag, n_mact, n_iact;
            d = big_endian ? swap32(bus_wdata) : bus_wdata;
            w = bus_sel && bus_wr;
            run  = (m_src == 1);
            tick = run && (m_div >= (1 << m_ps) - 1);
            n_div = (!run || tick) ? 0 : m_div + 1;
            n_cnt = m_cnt; setf = 0;
            if (w && bus_addr == 8'h04) n_cnt = m_iact;
            else if (tick) begin
                if (m_cnt == m_mact) begin n_cnt = m_iact; setf = 1; end
                else n_cnt = (m_cnt + 1) % 65536;
            end
            n_flag = m_flag;
            if (setf) n_flag = 1;
            else if (w && bus_addr == 8'h00 && !d[7]) n_flag = 0;
            n_mact = (m_src == 0) ? m_mbuf : m_mact;
            n_iact = (m_src == 0) ? m_ibuf : m_iact;
            if (w && bus_addr == 8'h08) m_mbuf = int'(d[15:0]);
            if (w && bus_addr == 8'h4C) m_ibuf = int'(d[15:0]);
            if (w && bus_addr == 8'h00) begin
                m_ps = int'(d[2:0]); m_src = int'(d[4:3]); m_ien = int'(d[6]);
            end
            m_cnt = n_cnt; m_div = n_div; m_flag = n_flag;
            m_mact = n_mact; m_iact = n_iact;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Interrupt level compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done)
            chk("R7 irq level vs model", {31'b0, irq}, {31'b0, (m_flag != 0) && (m_ien != 0)});
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a;
        bus_wdata = big_endian ? swap32(d) : d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_model(input string tag, input logic [7:0] a);
        bus_addr = a; #1;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic rd_exp(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] held;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_exp("R1 ctrl reset", 8'h00, 32'h0);
        rd_exp("R1 count reset", 8'h04, 32'h0);
        rd_exp("R1 modulo reset", 8'h08, 32'h0);
        rd_exp("R1 init reset", 8'h4C, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        rd_exp("R10 unmapped read", 8'h10, 32'h0);

        // R5 load while stopped, R4 count write reload
        wr_reg(8'h4C, 32'h0000_0010);
        wr_reg(8'h08, 32'h0000_0013);
        idle(2);
        rd_exp("R5 modulo loaded while off", 8'h08, 32'h13);
        rd_exp("R5 init loaded while off", 8'h4C, 32'h10);
        wr_reg(8'h04, 32'hDEAD_ABCD);
        rd_exp("R4 count write loads init", 8'h04, 32'h10);

        // R2/R3 ps=0 run, period = 4 counts
        wr_reg(8'h00, 32'h48);
        rd_exp("R10 ctrl layout", 8'h00, 32'h48);
        rd_exp("R2 no count on enable edge", 8'h04, 32'h10);
        for (int i = 1; i <= 3; i++) begin
            idle(1);
            rd_exp("R2 count step ps0", 8'h04, 32'h10 + 32'(i));
        end
        idle(1);
        rd_exp("R3 wrap reloads init", 8'h04, 32'h10);
        rd_exp("R3 flag set on wrap", 8'h00, 32'hC8);
        chk("R7 irq after wrap", {31'b0, irq}, 32'h1);

        // R6 write 1 keeps flag, write 0 clears
        wr_reg(8'h00, 32'hC0);
        rd_exp("R6 write one keeps flag", 8'h00, 32'hC0);
        bus_addr = 8'h04; #1; held = bus_rdata;
        idle(3);
        rd_exp("R2 stopped count holds", 8'h04, held);
        wr_reg(8'h00, 32'h40);
        rd_exp("R6 write zero clears flag", 8'h00, 32'h40);
        chk("R7 irq low after clear", {31'b0, irq}, 32'h0);

        // R5 shadow locked while running
        wr_reg(8'h00, 32'h48);
        wr_reg(8'h08, 32'h30);
        idle(2);
        rd_exp("R5 modulo locked while running", 8'h08, 32'h13);
        wr_reg(8'h00, 32'h40);
        idle(2);
        rd_exp("R5 modulo loads after stop", 8'h08, 32'h30);

        // R8 parked state
        wr_reg(8'h00, 32'h50);
        wr_reg(8'h08, 32'h44);
        bus_addr = 8'h04; #1; held = bus_rdata;
        idle(5);
        rd_exp("R8 parked modulo not loaded", 8'h08, 32'h30);
        rd_exp("R8 parked count holds", 8'h04, held);
        wr_reg(8'h00, 32'h40);
        idle(2);
        rd_exp("R8 buffer loads once off", 8'h08, 32'h44);

        // R2 prescaler ps=3, full first period
        wr_reg(8'h04, 32'h0);
        wr_reg(8'h00, 32'h4B);
        for (int k = 1; k <= 7; k++) begin
            idle(1);
            rd_exp("R2 ps3 holds within period", 8'h04, 32'h10);
        end
        idle(1);
        rd_exp("R2 ps3 first count after 8", 8'h04, 32'h11);
        idle(8);
        rd_exp("R2 ps3 second count", 8'h04, 32'h12);

        // R6 clear racing hardware set: period 2, clear every cycle
        wr_reg(8'h00, 32'h40);
        wr_reg(8'h08, 32'h11);
        idle(2);
        wr_reg(8'h04, 32'h0);
        wr_reg(8'h00, 32'h48);
        for (int j = 0; j < 12; j++) begin
            wr_reg(8'h00, 32'h48);
            rd_model("R6 set wins over clear", 8'h00);
            rd_model("R3 count vs model", 8'h04);
        end

        // R9 reversed byte order
        wr_reg(8'h00, 32'h40);
        big_endian = 1'b1;
        rd_exp("R9 ctrl swapped read", 8'h00, 32'h4000_0000);
        wr_reg(8'h08, 32'h0000_0102);
        idle(2);
        rd_exp("R9 modulo swapped", 8'h08, 32'h0201_0000);
        wr_reg(8'h00, 32'h48);
        rd_exp("R9 ctrl swapped write", 8'h00, 32'h4800_0000);
        idle(3);
        rd_model("R9 count swapped", 8'h04);
        wr_reg(8'h00, 32'h40);
        big_endian = 1'b0;

        // R10 unmapped write ignored
        wr_reg(8'h20, 32'hFFFF_FFFF);
        idle(2);
        rd_model("R10 ctrl after stray write", 8'h00);
        rd_model("R10 modulo after stray write", 8'h08);
        rd_model("R10 init after stray write", 8'h4C);
        rd_model("R10 count after stray write", 8'h04);
        rd_exp("R10 stray offset reads zero", 8'h20, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule